// File: doc/BRIEF.md
# Multi-Line SPI DAC Master

This block is a serial master for a fast digital-to-analog converter. It talks over a bus with one, two or four data lanes and drives the serial clock at a fixed half of its own input clock. It runs register transactions: an instruction byte followed by 8 or 16 data bits, written out or read back. It can also stream converter samples continuously, and both kinds of traffic use either single-edge (SDR) or both-edge (DDR) timing.

A register access is offered on a valid/ready command port, and a one-cycle done pulse marks its end together with the read result. A stream starts with a one-cycle start pulse. Each two-channel sample pair (channel 0 first) is taken with a one-cycle pulse, and the pairs follow each other with no gap until a stop pulse arrives. The data lanes leave the block as separate out, in and drive-enable signals, so that the pad ring can build the tristate buffer. A separate pin tells the converter when quad mode is selected.

Top module: `mio_dac_spi`

## Requirements
- R1: While chip select is low, sclk changes level on every input clock after the first low cycle, so SCLK runs at half the input clock. A frame keeps chip select low for exactly (number of SCLK edges + 1) input clocks.
- R2: ioMode sets the lane count: 0 = one lane (sdio[0]), 1 = two lanes (sdio[1:0]), 2 = four lanes (sdio[3:0]), and 3 behaves as 0. Bits leave MSB first, and within one beat the highest-numbered lane carries the earliest bit.
- R3: quadSel is high exactly when ioMode equals 2.
- R4: A register access sends an instruction byte {cmdRead, cmdAddr[6:0]} first. Then come 16 data bits when cmdWide is 1, or 8 bits (cmdWrData[7:0]) when it is 0. The data go out MSB first.
- R5: With ddrMode = 0, each beat is held for one full SCLK period and taken on the rising edge, so a frame of N beats has 2N edges. With ddrMode = 1, each beat is held for one input clock and taken on every edge, so N beats give N edges.
- R6: During the data phase of a read, sdioOe (1 = block drives) is low. The read bits are sampled on the SCLK edge that follows each beat (the rising edge only in SDR). At the cmdDone pulse, cmdRdData holds the value, with an 8-bit read zero-extended.
- R7: The first SCLK edge comes one input clock after chip select falls. Chip select rises in the input clock after the last edge, and it stays high for at least two input clocks between frames.
- R8: A stream sends each pair as {smpCh0, smpCh1}, 32 bits, back to back under one chip-select low. smpTaken pulses once for each pair loaded. In quad mode a 16-bit word goes out every 8 input clocks in SDR and every 4 in DDR, which is one pair every 16 or 8 clocks.
- R9: After streamStop, the pair being sent completes and no further pair is taken. This also holds when the stop arrives in the same clock as the reload edge.
- R10: When streamStart and cmdValid are high in the same idle cycle, the stream wins. cmdReady is low in that cycle, and the command is accepted after the stream has ended.
- R11: After reset, csn is 1, sclk is 0, cmdReady is 1 and sdioOe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstn | input | 1 | Asynchronous active-low reset |
| ioMode | input | 2 | Lane-count select |
| ddrMode | input | 1 | 1 = both-edge timing |
| cmdValid | input | 1 | Register command offered |
| cmdReady | output | 1 | Command accepted on this clock if valid |
| cmdRead | input | 1 | 1 = read access |
| cmdWide | input | 1 | 1 = 16-bit data, 0 = 8-bit |
| cmdAddr | input | 7 | Register address |
| cmdWrData | input | 16 | Write data |
| cmdDone | output | 1 | One-cycle pulse at end of access |
| cmdRdData | output | 16 | Read result |
| streamStart | input | 1 | Start streaming pulse |
| streamStop | input | 1 | Stop streaming pulse |
| smpCh0 | input | 16 | Channel 0 sample |
| smpCh1 | input | 16 | Channel 1 sample |
| smpTaken | output | 1 | Pulse when a sample pair was loaded |
| sclk | output | 1 | Serial clock |
| csn | output | 1 | Active-low chip select |
| sdioOut | output | 4 | Lane output values |
| sdioIn | input | 4 | Lane input values |
| sdioOe | output | 1 | 1 = drive lanes, 0 = release |
| quadSel | output | 1 | Quad mode indicator |

## Verification
Two events can meet in one cycle. The first is a stop request landing on the very clock edge where the next sample pair would be reloaded. The bench times a stop exactly one period minus one clock after a smpTaken pulse, then expects no further pulse and a frame length of just the pairs already taken. The second is a stream start offered in the same idle cycle as a register command. The bench expects cmdReady low in that cycle, the stream's bytes first, and the command's bytes in a later frame.

// File: rtl/mio_dac_spi_pkg.sv
package mio_dac_spi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_TRAIL,
    ST_GAP
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadCmd;
    logic       loadPair;
    logic       shift;
    logic       capture;
    logic       clearRx;
    logic [1:0] laneLog;   // log2 of active lane count
  } dpStrobes_t;

  function automatic logic [1:0] laneLogOf(input logic [1:0] mode);
    if (mode == 2'd2) return 2'd2;
    if (mode == 2'd1) return 2'd1;
    return 2'd0;
  endfunction

endpackage

// File: rtl/mio_dac_spi_ctrl.sv
module mio_dac_spi_ctrl
  import mio_dac_spi_pkg::*;
#(
  parameter int INSTR_W = 8,
  parameter int DATA_W  = 16,
  parameter int SHIFT_W = 32
) (
  input  logic       clk,
  input  logic       rstn,
  input  logic [1:0] ioMode,
  input  logic       ddrMode,
  input  logic       cmdValid,
  input  logic       cmdRead,
  input  logic       cmdWide,
  input  logic       streamStart,
  input  logic       streamStop,
  output logic       cmdReady,
  output logic       cmdDone,
  output logic       smpTaken,
  output logic       sclk,
  output logic       csn,
  output logic       sdioOe,
  output dpStrobes_t stb
);

  localparam int CNT_W = $clog2(SHIFT_W) + 1;
  localparam logic [CNT_W-1:0] PAIR_BITS = CNT_W'(SHIFT_W);
  localparam logic [CNT_W-1:0] WIDE_BITS = CNT_W'(INSTR_W + DATA_W);
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(INSTR_W + 8);
  localparam logic [CNT_W-1:0] WIDE_DATA = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] BYTE_DATA = CNT_W'(8);

  ctrlState_t       state;
  logic [1:0]       laneLog;
  logic             ddrQ, readQ, streamQ, dataPh, stopReq, gapQ;
  logic [CNT_W-1:0] beatCnt, dataBeats;

  logic [1:0] laneNow;
  logic       inAct, shiftPoint, lastBeat, stopNow, acceptStream, acceptCmd, reloadNow;

  always_comb begin
    laneNow      = laneLogOf(ioMode);
    inAct        = (state == ST_ACT);
    shiftPoint   = inAct && (ddrQ || sclk);
    lastBeat     = (beatCnt == CNT_W'(1));
    stopNow      = stopReq || streamStop;
    acceptStream = (state == ST_IDLE) && streamStart;
    acceptCmd    = (state == ST_IDLE) && !streamStart && cmdValid;
    reloadNow    = shiftPoint && lastBeat && streamQ && !stopNow;
    cmdReady     = (state == ST_IDLE) && !streamStart;
    sdioOe       = !(readQ && dataPh);
    stb.loadCmd  = acceptCmd;
    stb.loadPair = acceptStream || reloadNow;
    stb.shift    = shiftPoint && !lastBeat;
    stb.capture  = inAct && dataPh && readQ && (ddrQ || !sclk);
    stb.clearRx  = acceptCmd;
    stb.laneLog  = laneLog;
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      state     <= ST_IDLE;
      csn       <= 1'b1;
      sclk      <= 1'b0;
      laneLog   <= 2'd0;
      ddrQ      <= 1'b0;
      readQ     <= 1'b0;
      streamQ   <= 1'b0;
      dataPh    <= 1'b0;
      stopReq   <= 1'b0;
      gapQ      <= 1'b0;
      beatCnt   <= '0;
      dataBeats <= '0;
      cmdDone   <= 1'b0;
      smpTaken  <= 1'b0;
    end else begin
      cmdDone  <= 1'b0;
      smpTaken <= 1'b0;
      if (state == ST_IDLE) stopReq <= 1'b0;
      else if (streamStop)  stopReq <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (acceptStream) begin
            state     <= ST_ACT;
            csn       <= 1'b0;
            sclk      <= 1'b0;
            laneLog   <= laneNow;
            ddrQ      <= ddrMode;
            readQ     <= 1'b0;
            streamQ   <= 1'b1;
            dataPh    <= 1'b0;
            dataBeats <= '0;
            beatCnt   <= PAIR_BITS >> laneNow;
            smpTaken  <= 1'b1;
          end else if (acceptCmd) begin
            state     <= ST_ACT;
            csn       <= 1'b0;
            sclk      <= 1'b0;
            laneLog   <= laneNow;
            ddrQ      <= ddrMode;
            readQ     <= cmdRead;
            streamQ   <= 1'b0;
            dataPh    <= 1'b0;
            dataBeats <= (cmdWide ? WIDE_DATA : BYTE_DATA) >> laneNow;
            beatCnt   <= (cmdWide ? WIDE_BITS : BYTE_BITS) >> laneNow;
          end
        end
        ST_ACT: begin
          if (!shiftPoint) begin
            sclk <= 1'b1;                 // SDR rising edge, beat held
          end else begin
            sclk <= ~sclk;
            if (lastBeat) begin
              if (streamQ && !stopNow) begin
                beatCnt  <= PAIR_BITS >> laneLog;
                smpTaken <= 1'b1;
              end else begin
                state <= ST_TRAIL;
              end
            end else begin
              beatCnt <= beatCnt - CNT_W'(1);
              if (beatCnt == dataBeats + CNT_W'(1)) dataPh <= 1'b1;
            end
          end
        end
        ST_TRAIL: begin
          csn    <= 1'b1;
          dataPh <= 1'b0;
          gapQ   <= 1'b0;
          state  <= ST_GAP;
        end
        ST_GAP: begin
          if (gapQ) begin
            state   <= ST_IDLE;
            cmdDone <= !streamQ;
          end else begin
            gapQ <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: chip select, once raised, stays high the next clock too
  a_r7_csn_gap: assert property (@(posedge clk) disable iff (!rstn)
    $rose(csn) |=> csn);
  // R1: serial clock is parked low whenever chip select is high
  a_r1_sclk_parked: assert property (@(posedge clk) disable iff (!rstn)
    csn |-> !sclk);
  // R6: lanes are only released inside a frame
  a_r6_release_in_frame: assert property (@(posedge clk) disable iff (!rstn)
    !sdioOe |-> !csn);
  // R10: a command is only offered ready outside a frame
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rstn)
    cmdReady |-> csn);
  // R8: a pair is only taken inside a frame
  a_r8_taken_in_frame: assert property (@(posedge clk) disable iff (!rstn)
    smpTaken |-> !csn);

endmodule

// File: rtl/mio_dac_spi_dp.sv
module mio_dac_spi_dp
  import mio_dac_spi_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstn,
  input  dpStrobes_t        stb,
  input  logic              cmdRead,
  input  logic              cmdWide,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic [DATA_W-1:0] smpCh0,
  input  logic [DATA_W-1:0] smpCh1,
  input  logic [3:0]        sdioIn,
  output logic [3:0]        sdioOut,
  output logic [DATA_W-1:0] rdData
);

  localparam int INSTR_W = ADDR_W + 1;
  localparam int SHIFT_W = 2 * DATA_W;
  localparam int PAD_W16 = SHIFT_W - INSTR_W - DATA_W;
  localparam int PAD_W8  = SHIFT_W - INSTR_W - 8;

  logic [SHIFT_W-1:0] shreg;
  logic [DATA_W-1:0]  rx;
  logic [INSTR_W-1:0] instr;
  logic [SHIFT_W-1:0] cmdWord;
  logic [2:0]         laneCnt;

  always_comb begin
    instr   = {cmdRead, cmdAddr};
    cmdWord = cmdWide ? {instr, cmdWrData, {PAD_W16{1'b0}}}
                      : {instr, cmdWrData[7:0], {PAD_W8{1'b0}}};
    laneCnt = 3'd1 << stb.laneLog;
    case (stb.laneLog)
      2'd2:    sdioOut = shreg[SHIFT_W-1 -: 4];
      2'd1:    sdioOut = {2'b00, shreg[SHIFT_W-1 -: 2]};
      default: sdioOut = {3'b000, shreg[SHIFT_W-1]};
    endcase
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      shreg <= '0;
    end else if (stb.loadCmd) begin
      shreg <= cmdWord;
    end else if (stb.loadPair) begin
      shreg <= {smpCh0, smpCh1};
    end else if (stb.shift) begin
      shreg <= shreg << laneCnt;
    end
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      rx <= '0;
    end else if (stb.clearRx) begin
      rx <= '0;
    end else if (stb.capture) begin
      case (stb.laneLog)
        2'd2:    rx <= {rx[DATA_W-5:0], sdioIn};
        2'd1:    rx <= {rx[DATA_W-3:0], sdioIn[1:0]};
        default: rx <= {rx[DATA_W-2:0], sdioIn[0]};
      endcase
    end
  end

  assign rdData = rx;

  // R8: a command load and a pair load never meet
  a_r8_single_load: assert property (@(posedge clk) disable iff (!rstn)
    !(stb.loadCmd && stb.loadPair));
  // R5: a pair reload replaces the shift of that beat
  a_r5_no_shift_on_reload: assert property (@(posedge clk) disable iff (!rstn)
    stb.shift |-> !stb.loadPair);
  // R6: read sampling never coincides with a fresh command load
  a_r6_no_capture_on_load: assert property (@(posedge clk) disable iff (!rstn)
    stb.capture |-> !stb.loadCmd);

endmodule

// File: rtl/mio_dac_spi.sv
module mio_dac_spi
  import mio_dac_spi_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstn,
  input  logic [1:0]        ioMode,
  input  logic              ddrMode,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdRead,
  input  logic              cmdWide,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWrData,
  output logic              cmdDone,
  output logic [DATA_W-1:0] cmdRdData,
  input  logic              streamStart,
  input  logic              streamStop,
  input  logic [DATA_W-1:0] smpCh0,
  input  logic [DATA_W-1:0] smpCh1,
  output logic              smpTaken,
  output logic              sclk,
  output logic              csn,
  output logic [3:0]        sdioOut,
  input  logic [3:0]        sdioIn,
  output logic              sdioOe,
  output logic              quadSel
);

  localparam int INSTR_W = ADDR_W + 1;
  localparam int SHIFT_W = 2 * DATA_W;

  dpStrobes_t stb;

  mio_dac_spi_ctrl #(
    .INSTR_W(INSTR_W), .DATA_W(DATA_W), .SHIFT_W(SHIFT_W)
  ) u_ctrl (
    .clk(clk), .rstn(rstn), .ioMode(ioMode), .ddrMode(ddrMode),
    .cmdValid(cmdValid), .cmdRead(cmdRead), .cmdWide(cmdWide),
    .streamStart(streamStart), .streamStop(streamStop),
    .cmdReady(cmdReady), .cmdDone(cmdDone), .smpTaken(smpTaken),
    .sclk(sclk), .csn(csn), .sdioOe(sdioOe), .stb(stb)
  );

  mio_dac_spi_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstn(rstn), .stb(stb), .cmdRead(cmdRead), .cmdWide(cmdWide),
    .cmdAddr(cmdAddr), .cmdWrData(cmdWrData), .smpCh0(smpCh0), .smpCh1(smpCh1),
    .sdioIn(sdioIn), .sdioOut(sdioOut), .rdData(cmdRdData)
  );

  assign quadSel = (ioMode == 2'd2);

endmodule

// File: tb/tb_mio_dac_spi.sv
module tb_mio_dac_spi;

  logic        clk = 1'b0;
  logic        rstn = 1'b0;
  logic [1:0]  ioMode = 2'd0;
  logic        ddrMode = 1'b0;
  logic        cmdValid = 1'b0, cmdRead = 1'b0, cmdWide = 1'b0;
  logic [6:0]  cmdAddr = '0;
  logic [15:0] cmdWrData = '0;
  logic        streamStart = 1'b0, streamStop = 1'b0;
  logic [15:0] smpCh0 = '0, smpCh1 = '0;
  logic [3:0]  sdioIn;
  logic        cmdReady, cmdDone, smpTaken, sclk, csn, sdioOe, quadSel;
  logic [15:0] cmdRdData;
  logic [3:0]  sdioOut;

  always #2 clk = ~clk;

  mio_dac_spi dut (
    .clk(clk), .rstn(rstn), .ioMode(ioMode), .ddrMode(ddrMode),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdRead(cmdRead), .cmdWide(cmdWide),
    .cmdAddr(cmdAddr), .cmdWrData(cmdWrData), .cmdDone(cmdDone), .cmdRdData(cmdRdData),
    .streamStart(streamStart), .streamStop(streamStop), .smpCh0(smpCh0), .smpCh1(smpCh1),
    .smpTaken(smpTaken), .sclk(sclk), .csn(csn), .sdioOut(sdioOut), .sdioIn(sdioIn),
    .sdioOe(sdioOe), .quadSel(quadSel)
  );

  int checks = 0, errors = 0;
  logic [7:0] expByteQ [$];
  int         expEdgeQ [$];
  string      curReq = "R4";
  logic [15:0] rdShift = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int laneW(input logic [1:0] m);
    return (m == 2'd2) ? 4 : (m == 2'd1) ? 2 : 1;
  endfunction

  always_comb begin
    case (laneW(ioMode))
      4:       sdioIn = rdShift[15:12];
      2:       sdioIn = {2'b00, rdShift[15:14]};
      default: sdioIn = {3'b000, rdShift[15]};
    endcase
  end

  // monitor: converter model and scoreboard
  logic       pcsn = 1'b1, psclk = 1'b0, poe = 1'b1;
  logic [3:0] pOut = '0;
  logic [7:0] acc = '0;
  int edges = 0, lowCnt = 0, highCnt = 0, bitCnt = 0, frames = 0, cyc = 0, lastTaken = -1;

  always @(negedge clk) begin
    if (rstn) begin
      int w;
      w = laneW(ioMode);
      cyc++;
      if (pcsn && !csn) begin
        if (frames > 0) check(highCnt >= 2, "R7", highCnt, 2);
        edges = 0; lowCnt = 0; bitCnt = 0; lastTaken = -1;
      end
      if (!pcsn && !csn && (sclk != psclk)) begin
        edges++;
        if (edges == 1) check(lowCnt == 1, "R7", lowCnt, 1);
        if (ddrMode || (sclk && !psclk)) begin
          if (poe) begin
            for (int i = w - 1; i >= 0; i--) begin
              acc = {acc[6:0], pOut[i]};
              bitCnt++;
              if (bitCnt == 8) begin
                bitCnt = 0;
                if (expByteQ.size() == 0) check(1'b0, curReq, acc, 0);
                else begin
                  logic [7:0] e;
                  e = expByteQ.pop_front();
                  check(acc == e, curReq, acc, e);
                end
              end
            end
          end else begin
            rdShift = rdShift << w;
          end
        end
      end
      if (!pcsn && csn) begin
        if (expEdgeQ.size() == 0) check(1'b0, "R5", edges, 0);
        else begin
          int e;
          e = expEdgeQ.pop_front();
          check(edges == e, "R5", edges, e);
        end
        check(lowCnt == edges + 1, "R1", lowCnt, edges + 1);
        check(bitCnt == 0, "R4", bitCnt, 0);
        frames++;
      end
      if (smpTaken) begin
        int per;
        per = (32 / w) * (ddrMode ? 1 : 2);
        if (lastTaken >= 0) check(cyc - lastTaken == per, "R8", cyc - lastTaken, per);
        lastTaken = cyc;
      end
      if (!csn) lowCnt++;
      if (csn) highCnt++; else highCnt = 0;
      pcsn = csn; psclk = sclk; poe = sdioOe; pOut = sdioOut;
    end
  end

  task automatic pushCmd(input bit rd, input bit wide, input logic [6:0] addr, input logic [15:0] wd);
    int w, beats;
    w = laneW(ioMode);
    expByteQ.push_back({rd, addr});
    if (!rd) begin
      if (wide) expByteQ.push_back(wd[15:8]);
      expByteQ.push_back(wd[7:0]);
    end
    beats = (wide ? 24 : 16) / w;
    expEdgeQ.push_back(ddrMode ? beats : 2 * beats);
  endtask

  task automatic handshakeCmd(input bit rd, input bit wide, input logic [15:0] rv);
    cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    while (!cmdDone) @(negedge clk);
    if (rd) check(cmdRdData == (wide ? rv : {8'h00, rv[7:0]}), "R6", cmdRdData,
                  wide ? rv : {8'h00, rv[7:0]});
    repeat (2) @(negedge clk);
  endtask

  task automatic regAccess(input bit rd, input bit wide, input logic [6:0] addr,
                           input logic [15:0] wd, input logic [15:0] rv);
    @(negedge clk);
    cmdRead = rd; cmdWide = wide; cmdAddr = addr; cmdWrData = wd;
    rdShift = wide ? rv : {rv[7:0], 8'h00};
    pushCmd(rd, wide, addr, wd);
    handshakeCmd(rd, wide, rv);
  endtask

  task automatic setPair(input int k);
    smpCh0 = {12'(k * 37 + 12'h5A3), 4'h0};
    smpCh1 = 16'h3C96 ^ 16'(k * 16'h0F0F);
  endtask

  task automatic runStream(input int nPairs, input bit aligned, input bit withCmd);
    int taken, per, extra, w;
    w = laneW(ioMode);
    per = (32 / w) * (ddrMode ? 1 : 2);
    taken = 0; extra = 0;
    @(negedge clk);
    setPair(0);
    streamStart = 1'b1;
    if (withCmd) begin
      cmdRead = 1'b0; cmdWide = 1'b1; cmdAddr = 7'h2B; cmdWrData = 16'hC3E1;
      cmdValid = 1'b1;
      #0;
      check(cmdReady == 1'b0, "R10", cmdReady, 0);
    end
    @(negedge clk);
    streamStart = 1'b0;
    while (taken < nPairs) begin
      if (smpTaken) begin
        expByteQ.push_back(smpCh0[15:8]); expByteQ.push_back(smpCh0[7:0]);
        expByteQ.push_back(smpCh1[15:8]); expByteQ.push_back(smpCh1[7:0]);
        taken++;
        setPair(taken);
      end
      if (taken < nPairs) @(negedge clk);
    end
    repeat (aligned ? per - 1 : 3) @(negedge clk);
    streamStop = 1'b1;
    expEdgeQ.push_back(nPairs * (32 / w) * (ddrMode ? 1 : 2));
    @(negedge clk);
    streamStop = 1'b0;
    while (!csn) begin
      if (smpTaken) extra++;
      @(negedge clk);
    end
    check(extra == 0, "R9", extra, 0);
    if (withCmd) begin
      curReq = "R10";
      pushCmd(1'b0, 1'b1, 7'h2B, 16'hC3E1);
      handshakeCmd(1'b0, 1'b1, 16'h0);
    end else begin
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(csn == 1'b1, "R11", csn, 1);
    check(sclk == 1'b0, "R11", sclk, 0);
    check(cmdReady == 1'b1, "R11", cmdReady, 1);
    check(sdioOe == 1'b1, "R11", sdioOe, 1);
    rstn = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      ioMode = 2'(m);
      #1;
      check(quadSel == (m == 2), "R3", quadSel, m == 2);
    end
    // writes
    curReq = "R4"; ioMode = 2'd0; ddrMode = 1'b0; regAccess(1'b0, 1'b0, 7'h15, 16'h00A7, 16'h0);
    curReq = "R2"; ioMode = 2'd1; ddrMode = 1'b1; regAccess(1'b0, 1'b1, 7'h4C, 16'hBEEF, 16'h0);
    curReq = "R4"; ioMode = 2'd2; ddrMode = 1'b0; regAccess(1'b0, 1'b1, 7'h01, 16'h1234, 16'h0);
    curReq = "R5"; ioMode = 2'd2; ddrMode = 1'b1; regAccess(1'b0, 1'b0, 7'h7F, 16'h005A, 16'h0);
    curReq = "R2"; ioMode = 2'd3; ddrMode = 1'b0; regAccess(1'b0, 1'b0, 7'h33, 16'h00C1, 16'h0);
    // reads
    curReq = "R6"; ioMode = 2'd2; ddrMode = 1'b0; regAccess(1'b1, 1'b1, 7'h22, 16'h0, 16'h9D4B);
    ioMode = 2'd0; ddrMode = 1'b0; regAccess(1'b1, 1'b0, 7'h0E, 16'h0, 16'h00E6);
    ioMode = 2'd1; ddrMode = 1'b1; regAccess(1'b1, 1'b1, 7'h51, 16'h0, 16'h6A3C);
    ioMode = 2'd2; ddrMode = 1'b1; regAccess(1'b1, 1'b0, 7'h40, 16'h0, 16'h0081);
    // streams
    curReq = "R8"; ioMode = 2'd2; ddrMode = 1'b0; runStream(3, 1'b0, 1'b0);
    curReq = "R9"; ioMode = 2'd2; ddrMode = 1'b1; runStream(4, 1'b1, 1'b0);
    curReq = "R8"; ioMode = 2'd2; ddrMode = 1'b0; runStream(2, 1'b1, 1'b1);
    check(expByteQ.size() == 0, "R4", expByteQ.size(), 0);
    check(expEdgeQ.size() == 0, "R5", expEdgeQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule